// File: doc/BRIEF.md
# Secure-Aware Interrupt Acknowledge Filter

This block stands between a processor's reads of its interrupt interface and the arbiter that names the current highest-priority pending interrupt. It serves two read types:

- An acknowledge read may activate the pending interrupt.
- A peek read only reports the highest pending ID.

In both cases the block decides which ID the accessor may see. That depends on the security attribute of the access, on the group of the pending interrupt, and on a small set of configuration bits. When the interrupt is in a group the accessor may not see, the block returns a reserved ID instead: 1023 means "nothing for you", and 1022 means "pending, but for the other group".

The block also screens end-of-interrupt writes. It takes the interrupt ID from the low ten bits of the written word. It drops a non-secure completion that names a group 0 interrupt when security support is on. It signals every accepted completion with a one-cycle strobe that carries the ID.

Each request is registered. The returned ID, the acknowledge strobe and the completion strobe all appear one clock after the request cycle. The returned ID then holds until the next read.

Top module: `ack_filter`

## Requirements
- R1: After reset, rdData is 1023, and ackStrobe and eoiStrobe are low.
- R2: Groups are supported only when cfgRev2 or cfgSecExt is 1. With both at 0, a read returns pendId whatever pendGroup and accessSecure are.
- R3: With cfgSecExt at 0, every access is handled as secure. With cfgRev2 at 1, a non-secure read of a group 0 interrupt therefore sees its ID, and a read of a group 1 interrupt with ackCtl at 0 sees 1022.
- R4: With cfgSecExt at 1, a non-secure read whose pending interrupt is in group 0 (pendGroup = 0) returns 1023. A group 1 interrupt (pendGroup = 1) is visible to it.
- R5: When groups are supported, a secure read of a group 1 interrupt returns 1022 while ackCtl is 0 and the real ID while ackCtl is 1. A secure read of a group 0 interrupt always returns the real ID.
- R6: Group filtering applies only to real IDs, which are those below MAX_IRQ (1020). Any pendId of 1020 or above is returned unchanged.
- R7: An acknowledge read (rdAck = 1) that would see an ID of 1020 or above returns that ID and raises no ackStrobe.
- R8: An acknowledge read of a visible real ID whose pendPrio is not strictly below runPrio (equal or greater) returns 1023 and raises no ackStrobe.
- R9: An acknowledge read of a visible real ID with pendPrio < runPrio returns that ID. In the cycle after the request, ackStrobe is high for exactly one cycle and ackId equals the ID.
- R10: A peek read (rdAck = 0) never raises ackStrobe and applies no priority test. The returned ID holds in rdData until the next read.
- R11: With cfgSecExt at 1, a non-secure completion whose named interrupt is group 0 (eoiGroup = 0) raises no eoiStrobe and leaves eoiId unchanged. With cfgSecExt at 0, the same write is accepted.
- R12: An accepted completion raises eoiStrobe for one cycle in the cycle after the request, with eoiId equal to bits [9:0] of eoiData. The upper bits are ignored.
- R13: A secure completion of a group 1 interrupt is accepted even while ackCtl is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgSecExt | input | 1 | Security support present |
| cfgRev2 | input | 1 | Later controller revision (groups present without security) |
| ackCtl | input | 1 | Lets secure accesses see group 1 interrupts |
| accessSecure | input | 1 | Security attribute of the current access |
| rdReq | input | 1 | Read request this cycle |
| rdAck | input | 1 | 1 = acknowledge read, 0 = peek read |
| pendId | input | 10 | Arbiter's current pending ID |
| pendGroup | input | 1 | Group of the pending interrupt (1 = group 1) |
| pendPrio | input | 8 | Priority of the pending interrupt (lower is more urgent) |
| runPrio | input | 8 | Current running priority |
| eoiReq | input | 1 | End-of-interrupt write this cycle |
| eoiData | input | 32 | Written completion word |
| eoiGroup | input | 1 | Group of the interrupt named by the completion |
| rdData | output | 10 | Returned ID, held between reads |
| ackStrobe | output | 1 | One-cycle pulse: interrupt accepted for activation |
| ackId | output | 10 | ID of the last accepted acknowledge |
| eoiStrobe | output | 1 | One-cycle pulse: completion accepted |
| eoiId | output | 10 | ID of the last accepted completion |

## Verification
A table of read vectors sweeps the four configuration corners (no groups, groups without security, and security with each access type) against both groups and both settings of ackCtl. These vectors separate the 1022 and 1023 results from the real ID. Further vectors push reserved IDs, equal and higher priorities, and a priority-inverted peek read through both read types. They show that the priority test and the strobe belong to acknowledges only. Directed cases then cover completion writes with upper-bit noise, the dropped non-secure group 0 completion with its unchanged eoiId, and the pulse width and hold behaviour of the outputs.

// File: rtl/ack_filter_pkg.sv
package ack_filter_pkg;
  // Decisions handed from control to datapath for one cycle.
  typedef struct packed {
    logic loadRd;   // capture the returned ID
    logic fireAck;  // accepted acknowledge
    logic fireEoi;  // accepted completion
  } ackfStrobe_t;
endpackage

// File: rtl/ack_filter_view.sv
// Computes the ID a given access is allowed to see.
module ack_filter_view #(
  parameter int ID_W    = 10,
  parameter int MAX_IRQ = 1020
) (
  input  logic [ID_W-1:0] pendId,
  input  logic            pendGroup,
  input  logic            accessSecure,
  input  logic            cfgSecExt,
  input  logic            cfgRev2,
  input  logic            ackCtl,
  output logic [ID_W-1:0] viewId
);
  localparam logic [ID_W-1:0] ID_NONE   = ID_W'((1 << ID_W) - 1);
  localparam logic [ID_W-1:0] ID_OTHER  = ID_W'((1 << ID_W) - 2);
  localparam logic [ID_W-1:0] REAL_LIM  = ID_W'(MAX_IRQ);

  logic hasGroups;
  logic effSecure;
  logic isReal;

  assign hasGroups = cfgRev2 | cfgSecExt;         // R2
  assign effSecure = ~cfgSecExt | accessSecure;   // R3
  assign isReal    = pendId < REAL_LIM;           // R6

  always_comb begin
    viewId = pendId;
    if (isReal && hasGroups) begin
      if (!pendGroup && !effSecure) begin
        viewId = ID_NONE;                         // R4
      end else if (pendGroup && effSecure && !ackCtl) begin
        viewId = ID_OTHER;                        // R5
      end
    end
  end

  always_comb begin
    if (!hasGroups) begin
      assert_nogroup_passthru_R2: assert (viewId == pendId);
    end
  end
endmodule

// File: rtl/ack_filter_ctrl.sv
// Turns a request and the visible ID into strobes and a returned ID.
module ack_filter_ctrl
  import ack_filter_pkg::*;
#(
  parameter int ID_W    = 10,
  parameter int PRIO_W  = 8,
  parameter int MAX_IRQ = 1020
) (
  input  logic              rdReq,
  input  logic              rdAck,
  input  logic [ID_W-1:0]   viewId,
  input  logic [PRIO_W-1:0] pendPrio,
  input  logic [PRIO_W-1:0] runPrio,
  input  logic              eoiReq,
  input  logic              eoiGroup,
  input  logic              accessSecure,
  input  logic              cfgSecExt,
  output ackfStrobe_t       strobes,
  output logic [ID_W-1:0]   retId
);
  localparam logic [ID_W-1:0] ID_NONE  = ID_W'((1 << ID_W) - 1);
  localparam logic [ID_W-1:0] REAL_LIM = ID_W'(MAX_IRQ);

  logic viewReal;
  logic prioWins;
  logic eoiBlocked;

  assign viewReal   = viewId < REAL_LIM;
  assign prioWins   = pendPrio < runPrio;
  // R11: only a non-secure completion of group 0 under security support is dropped.
  // R13: group 1 secure completions pass regardless of ackCtl.
  assign eoiBlocked = cfgSecExt & ~accessSecure & ~eoiGroup;

  always_comb begin
    strobes = '0;
    retId   = viewId;
    if (rdReq) begin
      strobes.loadRd = 1'b1;
      if (rdAck) begin
        if (!viewReal) begin
          retId = viewId;                          // R7
        end else if (!prioWins) begin
          retId = ID_NONE;                         // R8
        end else begin
          strobes.fireAck = 1'b1;                  // R9
        end
      end
    end
    strobes.fireEoi = eoiReq & ~eoiBlocked;
  end

  always_comb begin
    if (strobes.fireAck) begin
      assert_ack_real_R9: assert (retId < REAL_LIM && pendPrio < runPrio);
    end
    if (!rdAck) begin
      assert_peek_no_fire_R10: assert (!strobes.fireAck);
    end
  end
endmodule

// File: rtl/ack_filter_datapath.sv
// Output registers driven by the control strobes.
module ack_filter_datapath
  import ack_filter_pkg::*;
#(
  parameter int ID_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ackfStrobe_t     strobes,
  input  logic [ID_W-1:0] retId,
  input  logic [ID_W-1:0] eoiIdIn,
  output logic [ID_W-1:0] rdData,
  output logic            ackStrobe,
  output logic [ID_W-1:0] ackId,
  output logic            eoiStrobe,
  output logic [ID_W-1:0] eoiId
);
  localparam logic [ID_W-1:0] ID_NONE = ID_W'((1 << ID_W) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData    <= ID_NONE;                        // R1
      ackStrobe <= 1'b0;
      ackId     <= ID_NONE;
      eoiStrobe <= 1'b0;
      eoiId     <= ID_NONE;
    end else begin
      ackStrobe <= strobes.fireAck;
      eoiStrobe <= strobes.fireEoi;
      if (strobes.loadRd)  rdData <= retId;
      if (strobes.fireAck) ackId  <= retId;
      if (strobes.fireEoi) eoiId  <= eoiIdIn;
    end
  end

  assert_ack_matches_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ackStrobe |-> ackId == rdData);
endmodule

// File: rtl/ack_filter.sv
module ack_filter
  import ack_filter_pkg::*;
#(
  parameter int ID_W    = 10,
  parameter int PRIO_W  = 8,
  parameter int EOI_W   = 32,
  parameter int MAX_IRQ = 1020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgSecExt,
  input  logic              cfgRev2,
  input  logic              ackCtl,
  input  logic              accessSecure,
  input  logic              rdReq,
  input  logic              rdAck,
  input  logic [ID_W-1:0]   pendId,
  input  logic              pendGroup,
  input  logic [PRIO_W-1:0] pendPrio,
  input  logic [PRIO_W-1:0] runPrio,
  input  logic              eoiReq,
  input  logic [EOI_W-1:0]  eoiData,
  input  logic              eoiGroup,
  output logic [ID_W-1:0]   rdData,
  output logic              ackStrobe,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiStrobe,
  output logic [ID_W-1:0]   eoiId
);
  localparam logic [ID_W-1:0] ID_NONE = ID_W'((1 << ID_W) - 1);

  logic [ID_W-1:0] viewId;
  logic [ID_W-1:0] retId;
  ackfStrobe_t     strobes;

  ack_filter_view #(.ID_W(ID_W), .MAX_IRQ(MAX_IRQ)) uView (
    .pendId(pendId), .pendGroup(pendGroup), .accessSecure(accessSecure),
    .cfgSecExt(cfgSecExt), .cfgRev2(cfgRev2), .ackCtl(ackCtl), .viewId(viewId)
  );

  ack_filter_ctrl #(.ID_W(ID_W), .PRIO_W(PRIO_W), .MAX_IRQ(MAX_IRQ)) uCtrl (
    .rdReq(rdReq), .rdAck(rdAck), .viewId(viewId), .pendPrio(pendPrio),
    .runPrio(runPrio), .eoiReq(eoiReq), .eoiGroup(eoiGroup),
    .accessSecure(accessSecure), .cfgSecExt(cfgSecExt),
    .strobes(strobes), .retId(retId)
  );

  ack_filter_datapath #(.ID_W(ID_W)) uData (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .retId(retId),
    .eoiIdIn(eoiData[ID_W-1:0]), .rdData(rdData), .ackStrobe(ackStrobe),
    .ackId(ackId), .eoiStrobe(eoiStrobe), .eoiId(eoiId)
  );

  assert_low_prio_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && rdAck && pendPrio >= runPrio) |=> (!ackStrobe && rdData >= ID_W'(MAX_IRQ)));

  assert_peek_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && !rdAck) |=> !ackStrobe);

  assert_ns_eoi_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoiReq && cfgSecExt && !accessSecure && !eoiGroup) |=> (!eoiStrobe && $stable(eoiId)));

  assert_eoi_low_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eoiReq && !(cfgSecExt && !accessSecure && !eoiGroup)) |=>
      (eoiStrobe && eoiId == ID_W'($past(eoiData))));

  assert_nogroup_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && !rdAck && !cfgSecExt && !cfgRev2) |=> rdData == $past(pendId));

  assert_ns_grp0_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && cfgSecExt && !accessSecure && !pendGroup && pendId < ID_W'(MAX_IRQ))
      |=> (rdData == ID_NONE && !ackStrobe));
endmodule

// File: tb/tb_ack_filter.sv
module tb_ack_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgSecExt = 0, cfgRev2 = 0, ackCtl = 0, accessSecure = 0;
  logic rdReq = 0, rdAck = 0, pendGroup = 0, eoiReq = 0, eoiGroup = 0;
  logic [9:0]  pendId = '0;
  logic [7:0]  pendPrio = '0, runPrio = 8'hff;
  logic [31:0] eoiData = '0;
  logic [9:0]  rdData, ackId, eoiId;
  logic        ackStrobe, eoiStrobe;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  ack_filter dut (
    .clk(clk), .rst_n(rst_n), .cfgSecExt(cfgSecExt), .cfgRev2(cfgRev2),
    .ackCtl(ackCtl), .accessSecure(accessSecure), .rdReq(rdReq), .rdAck(rdAck),
    .pendId(pendId), .pendGroup(pendGroup), .pendPrio(pendPrio), .runPrio(runPrio),
    .eoiReq(eoiReq), .eoiData(eoiData), .eoiGroup(eoiGroup), .rdData(rdData),
    .ackStrobe(ackStrobe), .ackId(ackId), .eoiStrobe(eoiStrobe), .eoiId(eoiId)
  );

  typedef struct packed {
    logic [7:0] req;
    logic       secExt, rev2, sec, actl, isAck, grp;
    logic [9:0] id;
    logic [7:0] prio, run;
    logic [9:0] expId;
    logic       expStb;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // req  sx   r2   sec  actl ack  grp  id        prio   run    exp       stb
    '{8'd2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd37,  8'h10,8'h80,10'd37,  1'b0}, // R2
    '{8'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,10'd40,  8'h10,8'h80,10'd40,  1'b1}, // R2
    '{8'd3, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,10'd5,   8'h10,8'h80,10'd5,   1'b0}, // R3
    '{8'd3, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,10'd6,   8'h10,8'h80,10'd1022,1'b0}, // R3
    '{8'd4, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,10'd7,   8'h10,8'h80,10'd1023,1'b0}, // R4
    '{8'd4, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,10'd8,   8'h10,8'h80,10'd8,   1'b0}, // R4
    '{8'd5, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,10'd9,   8'h10,8'h80,10'd1022,1'b0}, // R5
    '{8'd5, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,10'd9,   8'h10,8'h80,10'd9,   1'b0}, // R5
    '{8'd5, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,10'd10,  8'h10,8'h80,10'd10,  1'b0}, // R5
    '{8'd6, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,10'd1023,8'h10,8'h80,10'd1023,1'b0}, // R6
    '{8'd6, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,10'd1021,8'h10,8'h80,10'd1021,1'b0}, // R6
    '{8'd7, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,10'd12,  8'h00,8'hff,10'd1023,1'b0}, // R7
    '{8'd7, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,10'd13,  8'h00,8'hff,10'd1022,1'b0}, // R7
    '{8'd7, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,10'd1020,8'h00,8'hff,10'd1020,1'b0}, // R7
    '{8'd8, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,10'd14,  8'h40,8'h40,10'd1023,1'b0}, // R8
    '{8'd8, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,10'd15,  8'h90,8'h40,10'd1023,1'b0}, // R8
    '{8'd9, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,10'd100, 8'h20,8'h30,10'd100, 1'b1}, // R9
    '{8'd10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,10'd200, 8'h90,8'h10,10'd200, 1'b0}  // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_eoi(input logic sx, input logic sec, input logic grp,
                        input logic actl, input logic [31:0] data);
    cfgSecExt = sx; accessSecure = sec; eoiGroup = grp; ackCtl = actl;
    eoiData = data; eoiReq = 1'b1;
    @(negedge clk);
    eoiReq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdData", rdData, 1023);
    chk("R1 ackStrobe", ackStrobe, 0);
    chk("R1 eoiStrobe", eoiStrobe, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cfgSecExt = VECS[i].secExt; cfgRev2 = VECS[i].rev2;
      accessSecure = VECS[i].sec; ackCtl = VECS[i].actl;
      rdAck = VECS[i].isAck; pendGroup = VECS[i].grp; pendId = VECS[i].id;
      pendPrio = VECS[i].prio; runPrio = VECS[i].run;
      rdReq = 1'b1;
      @(negedge clk);
      rdReq = 1'b0;
      chk($sformatf("R%0d vec%0d rdData", VECS[i].req, i), rdData, VECS[i].expId);
      chk($sformatf("R%0d vec%0d ackStrobe", VECS[i].req, i), ackStrobe, VECS[i].expStb);
      if (VECS[i].expStb)
        chk($sformatf("R%0d vec%0d ackId", VECS[i].req, i), ackId, VECS[i].expId);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d pulse end", VECS[i].req, i), ackStrobe, 0);
    end

    // R10: returned ID holds with no read, even if the pending ID changes
    pendId = 10'd321;
    repeat (2) @(negedge clk);
    chk("R10 hold rdData", rdData, 200);

    // R12: accepted completion uses only bits [9:0]
    cfgRev2 = 1'b0;
    do_eoi(1'b1, 1'b1, 1'b0, 1'b0, 32'hFFFF_FC2A);
    chk("R12 eoiStrobe", eoiStrobe, 1);
    chk("R12 eoiId", eoiId, 42);
    @(negedge clk);
    chk("R12 eoi pulse end", eoiStrobe, 0);

    // R11: non-secure group 0 completion with security support is dropped
    do_eoi(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0077);
    chk("R11 dropped eoiStrobe", eoiStrobe, 0);
    chk("R11 eoiId unchanged", eoiId, 42);
    // R11: same write without security support is accepted
    do_eoi(1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0077);
    chk("R11 nosec eoiStrobe", eoiStrobe, 1);
    chk("R11 nosec eoiId", eoiId, 10'h077);

    // R13: secure completion of group 1 with ackCtl clear is accepted
    do_eoi(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_0155);
    chk("R13 eoiStrobe", eoiStrobe, 1);
    chk("R13 eoiId", eoiId, 10'h155);
    // R11: non-secure completion of group 1 is accepted
    do_eoi(1'b1, 1'b0, 1'b1, 1'b0, 32'h8000_0003);
    chk("R11 ns grp1 eoiId", eoiId, 3);

    // R9: back-to-back accepted acknowledges give two strobes
    cfgSecExt = 1'b0; cfgRev2 = 1'b0; rdAck = 1'b1; pendPrio = 8'h01; runPrio = 8'hff;
    pendId = 10'd50; rdReq = 1'b1;
    @(negedge clk);
    chk("R9 first ackId", ackId, 50);
    pendId = 10'd51;
    @(negedge clk);
    rdReq = 1'b0;
    chk("R9 second ackStrobe", ackStrobe, 1);
    chk("R9 second ackId", ackId, 51);
    @(negedge clk);
    chk("R9 strobe drops", ackStrobe, 0);

    // R1: reset mid-run restores the idle state
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset rdData", rdData, 1023);
    chk("R1 re-reset eoiId", eoiId, 1023);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule